// File: doc/BRIEF.md
# Priority-Escalating Retry Arbiter

This block sits at the home of one contended memory block and decides which of up to `N_NODES` requesters gets the block next. It holds a single waiting request in a one-entry slot. Every request that is not kept in that slot, and is not granted, is refused with a retry indication. The block keeps one priority counter per requester. A counter goes up by one on every refusal and returns to zero when that requester is granted. Repeated retries therefore gain ground until they win, so no requester is starved.

Each requester raises `req_i[n]` to ask for the block. `block_free_i` tells the arbiter that the block can be handed out in this cycle. Grant and refusal are one-cycle pulses, registered one clock after the request cycle. The counter update appears on `prio_o` at the same edge. The arbiter does not move data and does not perform coherence actions. It only orders requests.

Top module: `nack_retry_arb`

## Requirements
- R1: After reset the slot is empty, every priority counter is 0, and `grant_o` and `nack_o` are 0.
- R2: With the block free and the slot empty, a lone request is granted one cycle later: `grant_o` is one-hot at the requester and its counter is 0. A grant occurs only when `block_free_i` was 1 in the previous cycle.
- R3: With the block busy and the slot empty, a lone request is placed in the slot. `pend_valid_o` is 1, `pend_id_o` shows the requester, and no refusal is issued.
- R4: With the block busy, a request whose priority is strictly higher than the held one's replaces it. The node it replaces gets a `nack_o` pulse.
- R5: With the block busy, a request whose priority is lower than or equal to the held one's is refused in the next cycle, and the slot is unchanged.
- R6: When several requests of equal priority arrive together and the slot is empty, the lowest node index wins and the others are refused.
- R7: Each refusal raises that node's counter by exactly 1.
- R8: A counter that is already at its maximum, 2^PRIO_W-1 (7 by default), stays there when refused.
- R9: When the block becomes free, the held request is granted ahead of new requests of equal priority. The winner's counter resets to 0, the other requesters are refused, and the slot empties.
- R10: A request from the node already in the slot has no effect. That node receives no refusal, its counter is unchanged, and the slot is unchanged.
- R11: At most one node is granted per cycle, and no node is granted and refused in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_NODES | Request from each node (bit n = node n) |
| block_free_i | input | 1 | The block may be handed out this cycle |
| grant_o | output | N_NODES | One-cycle grant pulse per node |
| nack_o | output | N_NODES | One-cycle refusal (retry) pulse per node |
| pend_valid_o | output | 1 | The waiting slot holds a request |
| pend_id_o | output | $clog2(N_NODES) | Node held in the slot |
| prio_o | output | N_NODES*PRIO_W | Priority counters, node n at bits [n*PRIO_W +: PRIO_W] |

## Verification
The in-line properties check the following on every cycle:
- a one-hot grant that never coincides with a refusal to the same node;
- grants only after a free cycle;
- a counter step of +1, saturating, on each refusal;
- a zero counter at each grant;
- no refusal to the node held in the slot.

Which node wins a particular contest can only be shown by the directed scenarios. These cover replacement by a higher priority, losing a tie to the held request, the lowest-index rule among simultaneous arrivals, and the held request winning when the block frees. The scenarios also drive counters into saturation under sustained contention.

// File: rtl/nack_retry_arb.sv
module nack_retry_arb #(
  parameter int N_NODES = 4,
  parameter int PRIO_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_NODES-1:0]          req_i,
  input  logic                        block_free_i,
  output logic [N_NODES-1:0]          grant_o,
  output logic [N_NODES-1:0]          nack_o,
  output logic                        pend_valid_o,
  output logic [$clog2(N_NODES)-1:0]  pend_id_o,
  output logic [N_NODES*PRIO_W-1:0]   prio_o
);
  localparam int IDW = $clog2(N_NODES);
  localparam logic [PRIO_W-1:0] PMAX = {PRIO_W{1'b1}};

  logic [PRIO_W-1:0] prio_q [N_NODES];
  logic              pend_v_q;
  logic [IDW-1:0]    pend_id_q;

  logic [N_NODES-1:0] live_req;
  logic               best_v;
  logic [IDW-1:0]     best_id;
  logic [PRIO_W-1:0]  best_p;
  logic [N_NODES-1:0] grant_d, nack_d;

  always_comb begin
    best_v  = pend_v_q;
    best_id = pend_id_q;
    best_p  = prio_q[pend_id_q];
    for (int i = 0; i < N_NODES; i++) begin
      live_req[i] = req_i[i] && !(pend_v_q && pend_id_q == IDW'(i));
      if (live_req[i] && (!best_v || prio_q[i] > best_p)) begin
        best_v  = 1'b1;
        best_id = IDW'(i);
        best_p  = prio_q[i];
      end
    end
    grant_d = '0;
    nack_d  = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (best_v && best_id == IDW'(i)) grant_d[i] = block_free_i;
      else nack_d[i] = live_req[i] || (pend_v_q && pend_id_q == IDW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v_q  <= 1'b0;
      pend_id_q <= '0;
      grant_o   <= '0;
      nack_o    <= '0;
      for (int i = 0; i < N_NODES; i++) prio_q[i] <= '0;
    end else begin
      grant_o   <= grant_d;
      nack_o    <= nack_d;
      pend_v_q  <= best_v && !block_free_i;
      pend_id_q <= best_id;
      for (int i = 0; i < N_NODES; i++) begin
        if (grant_d[i]) prio_q[i] <= '0;
        else if (nack_d[i] && prio_q[i] != PMAX) prio_q[i] <= prio_q[i] + 1'b1;
      end
    end
  end

  assign pend_valid_o = pend_v_q;
  assign pend_id_o    = pend_id_q;

  genvar g;
  generate
    for (g = 0; g < N_NODES; g++) begin : g_node
      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];

      // R7 R8
      nack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o[g] |-> prio_q[g] == (($past(prio_q[g]) == PMAX) ? PMAX : $past(prio_q[g]) + 1'b1));

      // R9
      grant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[g] |-> prio_q[g] == '0);
    end
  endgenerate

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & nack_o) == '0));

  // R2
  grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> $past(block_free_i));

  // R10
  held_not_nacked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v_q |-> !nack_o[pend_id_q]);
endmodule

// File: tb/nack_retry_arb_tb_top.sv
module nack_retry_arb_tb_top;
  localparam int N = 4;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req;
  logic free;
  logic [N-1:0] grant, nack;
  logic pv;
  logic [1:0] pid;
  logic [N*PW-1:0] prio;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  nack_retry_arb #(.N_NODES(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .block_free_i(free),
    .grant_o(grant), .nack_o(nack), .pend_valid_o(pv), .pend_id_o(pid), .prio_o(prio));

  function automatic int pr(int n);
    return int'(prio[n*PW +: PW]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] r, logic f);
    @(negedge clk);
    req = r; free = f;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; req = '0; free = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 pend_valid", int'(pv), 0);
    chk("R1 grant", int'(grant), 0);
    chk("R1 nack", int'(nack), 0);
    chk("R1 prio", int'(prio), 0);
  endtask

  task automatic t_free_single;
    do_reset();
    step(4'b0100, 1'b1);
    chk("R2 grant", int'(grant), 4);
    chk("R2 nack", int'(nack), 0);
    chk("R2 prio2", pr(2), 0);
    step(4'b0000, 1'b0);
    chk("R2 grant pulse", int'(grant), 0);
  endtask

  task automatic t_hold_and_contest;
    do_reset();
    step(4'b0010, 1'b0);
    chk("R3 pend_valid", int'(pv), 1);
    chk("R3 pend_id", int'(pid), 1);
    chk("R3 nack", int'(nack), 0);
    step(4'b0010, 1'b0);
    chk("R10 nack", int'(nack), 0);
    chk("R10 prio1", pr(1), 0);
    chk("R10 pend_id", int'(pid), 1);
    step(4'b0001, 1'b0);
    chk("R5 nack", int'(nack), 1);
    chk("R5 pend_id", int'(pid), 1);
    chk("R7 prio0", pr(0), 1);
    step(4'b0001, 1'b0);
    chk("R4 pend_id", int'(pid), 0);
    chk("R4 nack displaced", int'(nack), 2);
    chk("R7 prio1", pr(1), 1);
    chk("R4 prio0 kept", pr(0), 1);
    step(4'b0000, 1'b0);
  endtask

  task automatic t_simultaneous;
    do_reset();
    step(4'b1100, 1'b0);
    chk("R6 pend_id", int'(pid), 2);
    chk("R6 nack", int'(nack), 8);
    chk("R6 prio3", pr(3), 1);
    step(4'b0000, 1'b0);
  endtask

  task automatic t_saturate_and_release;
    int holder;
    do_reset();
    for (int k = 0; k < 60; k++) step(4'b1110, 1'b0);
    chk("R8 prio1", pr(1), 7);
    chk("R8 prio2", pr(2), 7);
    chk("R8 prio3", pr(3), 7);
    chk("R8 prio0", pr(0), 0);
    holder = int'(pid);
    step(4'b1110, 1'b0);
    chk("R8 nack count", $countones(nack), 2);
    chk("R8 still max", pr(1) + pr(2) + pr(3), 21);
    step(4'b1110, 1'b1);
    chk("R9 grant", int'(grant), 1 << holder);
    chk("R9 prio reset", pr(holder), 0);
    chk("R9 nack others", int'(nack), 4'b1110 & ~(1 << holder));
    chk("R9 slot empty", int'(pv), 0);
    chk("R11 onehot", $countones(grant), 1);
    step(4'b0000, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; free = 1'b0;
    t_reset();
    t_free_single();
    t_hold_and_contest();
    t_simultaneous();
    t_saturate_and_release();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule